// File: doc/BRIEF.md
# Sixteen-Bit Timer with Capture and Compare

This block is a 16-bit up-counter paired with a 16-bit capture/compare register. The counter can be clocked from the instruction-cycle tick or from rising edges of an external clock pin. The external pin can pass through a two-stage synchroniser or bypass it. A prescaler of 1, 2, 4 or 8 sits between the clock source and the counter. The counter and the capture/compare register are loaded one byte at a time through write strobes, and both are visible on output ports. A sticky overflow flag records each wrap of the counter.

A 4-bit mode field sets what the capture/compare unit does.

- **Capture modes:** a selected edge on the capture pin, or every Nth rising edge, copies the counter into the register.
- **Compare modes:** the first cycle in which the counter equals the register is a match. A match can drive the compare output high, drive it low, only raise the event flag, or fire a special-event trigger. The special-event trigger also clears the counter.

The mode field is held in a state register. States: `CC_OFF`, `CC_CAP_FALL`, `CC_CAP_RISE`, `CC_CAP_RISE4`, `CC_CAP_RISE16`, `CC_CMP_SET`, `CC_CMP_CLR`, `CC_CMP_IRQ`, `CC_CMP_SPEV`.

On every clock the state moves to the state that decodes from the mode input. There are two kinds of transition:

- **Hold:** the decoded state equals the current state. Normal operation continues.
- **Switch:** the decoded state differs. In that cycle no capture or compare event is taken and the edge counter is cleared.

Top module: `tmr_cc`

## Requirements
- R1: After reset, `cnt`, `ccr`, `cmp_out`, `trig`, `ovf_flag` and `ev_flag` are all zero.
- R2: With `run_en`=1 the counter rises by one on each prescaled tick, and with `run_en`=0 it holds. Byte writes load the counter and take priority over increment and special-event clear. Writes and `run_en`=0 both clear the prescaler.
- R3: With `clk_sel`=0 the tick is `cyc_tick`, and `ext_nosync` has no effect. With `clk_sel`=1 the tick is a rising edge of `ext_clk`. If `ext_nosync`=1 the count changes at the first clock edge that sees the pin high. If `ext_nosync`=0 it changes at the third clock edge.
- R4: `presc` codes 00, 01, 10 and 11 give one counter increment per 1, 2, 4 and 8 ticks.
- R5: An increment from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed, and a new wrap wins over a clear in the same cycle.
- R6: Mode 0100 captures `cnt` into `ccr` on each falling edge of `cap_in`. Mode 0101 captures on each rising edge. The pin is synchronised with two stages.
- R7: Mode 0110 captures on every 4th rising edge of `cap_in`, and mode 0111 captures on every 16th.
- R8: A change of the mode field clears the partial edge count, so counting restarts after the change.
- R9: A capture in a cycle where the counter also increments stores the value before the increment.
- R10: In mode 1000 a match sets `cmp_out` to 1, and in mode 1001 a match clears it to 0. A match is the first cycle in which `cnt` equals `ccr`.
- R11: In mode 1010 a match sets only `ev_flag`, and `cmp_out` is unchanged.
- R12: In mode 1011 a match clears the counter to zero at the next edge and raises `trig` for exactly one cycle.
- R13: Every capture and every match sets `ev_flag`. The flag stays set until `ev_clr` is pulsed, and a new event wins over a clear.
- R14: A new mode takes effect one cycle after it is applied. Codes 0001–0011 and 11xx behave as off, with no capture, no match and no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | Instruction-cycle tick (internal clock source) |
| ext_clk | input | 1 | External clock pin |
| cap_in | input | 1 | Capture input pin |
| run_en | input | 1 | 1 runs the counter, 0 stops it |
| clk_sel | input | 1 | 0 selects internal tick, 1 selects external pin |
| ext_nosync | input | 1 | 1 bypasses the external-pin synchroniser |
| presc | input | 2 | Prescale code |
| mode | input | 4 | Capture/compare mode code |
| wdata | input | 8 | Byte written by the write strobes |
| cnt_lo_we | input | 1 | Write `wdata` into counter low byte |
| cnt_hi_we | input | 1 | Write `wdata` into counter high byte |
| ccr_lo_we | input | 1 | Write `wdata` into register low byte |
| ccr_hi_we | input | 1 | Write `wdata` into register high byte |
| ovf_clr | input | 1 | Clear overflow flag |
| ev_clr | input | 1 | Clear event flag |
| cnt | output | 16 | Counter value |
| ccr | output | 16 | Capture/compare register value |
| cmp_out | output | 1 | Compare output pin |
| trig | output | 1 | One-cycle special-event trigger |
| ovf_flag | output | 1 | Sticky overflow flag |
| ev_flag | output | 1 | Sticky capture/compare event flag |

## Verification
The in-line properties check these on every cycle:
- the counter holds when no source acts on it;
- a wrap sets the overflow flag, and the flag is sticky;
- a special-event clear zeroes the count;
- the trigger never lasts two cycles;
- each event sets the event flag;
- a capture stores the value the counter had before the edge;
- the output moves only in the set and clear modes;
- the edge count is cleared by a mode switch.

The following can only be shown by the bench scenarios, checked against the cycle model:
- the latency difference between synchronised and unsynchronised external clocks;
- the exact prescale ratios;
- counting to the 4th and 16th edge;
- the restart of that count after a mode switch;
- the special-event period;
- the behaviour of reserved mode codes.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    typedef enum logic [3:0] {
        CC_OFF,
        CC_CAP_FALL,
        CC_CAP_RISE,
        CC_CAP_RISE4,
        CC_CAP_RISE16,
        CC_CMP_SET,
        CC_CMP_CLR,
        CC_CMP_IRQ,
        CC_CMP_SPEV
    } cc_state_t;

    function automatic cc_state_t decode_mode(input logic [3:0] code);
        cc_state_t s;
        case (code)
            4'b0100: s = CC_CAP_FALL;
            4'b0101: s = CC_CAP_RISE;
            4'b0110: s = CC_CAP_RISE4;
            4'b0111: s = CC_CAP_RISE16;
            4'b1000: s = CC_CMP_SET;
            4'b1001: s = CC_CMP_CLR;
            4'b1010: s = CC_CMP_IRQ;
            4'b1011: s = CC_CMP_SPEV;
            default: s = CC_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_cc_clksel.sv
module tmr_cc_clksel #(
    parameter int PS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_tick,
    input  logic            ext_clk,
    input  logic            clk_sel,
    input  logic            ext_nosync,
    input  logic            run_en,
    input  logic [PS_W-1:0] presc,
    input  logic            cnt_wr,
    output logic            inc
);
    localparam int PC_W = (1 << PS_W) - 1;

    logic [SYNC_STAGES:0] ext_sh;
    logic [PC_W-1:0]      pcnt;
    logic [PC_W-1:0]      term;
    logic                 raw_edge, sync_edge, tick, at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
    end

    assign raw_edge  = ext_clk & ~ext_sh[0];
    assign sync_edge = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
    assign tick      = clk_sel ? (ext_nosync ? raw_edge : sync_edge) : cyc_tick;

    always_comb begin
        for (int i = 0; i < PC_W; i++) term[i] = (i < int'(presc));
    end

    assign at_term = (pcnt >= term);
    assign inc     = run_en & tick & at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pcnt <= '0;
        else if (!run_en || cnt_wr) pcnt <= '0;
        else if (tick)             pcnt <= at_term ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         lo_we,
    input  logic         hi_we,
    input  logic [7:0]   wdata,
    input  logic         spev_clr,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf_flag
);
    localparam int HI_W = W - 8;

    logic any_we, wrap;

    assign any_we = lo_we | hi_we;
    assign wrap   = inc & ~any_we & ~spev_clr & (&cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (any_we) begin
            if (lo_we) cnt[7:0]   <= wdata;
            if (hi_we) cnt[W-1:8] <= wdata[HI_W-1:0];
        end else if (spev_clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    a_r5_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&cnt) && !any_we && !spev_clr) |=> (ovf_flag && cnt == '0));
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !any_we && !spev_clr) |=> $stable(cnt));
    a_r12_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (spev_clr && !any_we) |=> (cnt == '0));
endmodule

// File: rtl/tmr_cc_ccunit.sv
module tmr_cc_ccunit
    import tmr_cc_pkg::*;
#(
    parameter int W           = 16,
    parameter int ECNT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   mode,
    input  logic         cap_in,
    input  logic [W-1:0] cnt,
    input  logic         lo_we,
    input  logic         hi_we,
    input  logic [7:0]   wdata,
    input  logic         ev_clr,
    output logic [W-1:0] ccr,
    output logic         cmp_out,
    output logic         trig,
    output logic         ev_flag,
    output logic         spev_clr
);
    localparam int HI_W = W - 8;
    localparam logic [ECNT_W-1:0] LAST4  = ECNT_W'(3);
    localparam logic [ECNT_W-1:0] LAST16 = ECNT_W'(15);

    cc_state_t            state, nxt;
    logic [SYNC_STAGES:0] cap_sh;
    logic [ECNT_W-1:0]    ecnt;
    logic                 rise, fall, eq, eq_q, mode_chg, cap_evt, cmp_evt, nth_mode;

    assign nxt      = decode_mode(mode);
    assign mode_chg = (nxt != state);
    assign rise     = cap_sh[SYNC_STAGES-1] & ~cap_sh[SYNC_STAGES];
    assign fall     = ~cap_sh[SYNC_STAGES-1] & cap_sh[SYNC_STAGES];
    assign eq       = (cnt == ccr);
    assign nth_mode = (state == CC_CAP_RISE4) || (state == CC_CAP_RISE16);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CC_OFF;
        else        state <= nxt;
    end

    // event decode per state
    always_comb begin
        cap_evt = 1'b0;
        cmp_evt = 1'b0;
        if (!mode_chg) begin
            unique case (state)
                CC_CAP_FALL:   cap_evt = fall;
                CC_CAP_RISE:   cap_evt = rise;
                CC_CAP_RISE4:  cap_evt = rise && (ecnt == LAST4);
                CC_CAP_RISE16: cap_evt = rise && (ecnt == LAST16);
                CC_CMP_SET, CC_CMP_CLR, CC_CMP_IRQ, CC_CMP_SPEV:
                               cmp_evt = eq && !eq_q;
                default:       ;
            endcase
        end
    end

    assign spev_clr = cmp_evt && (state == CC_CMP_SPEV);

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sh  <= '0;
            ecnt    <= '0;
            ccr     <= '0;
            cmp_out <= 1'b0;
            trig    <= 1'b0;
            ev_flag <= 1'b0;
            eq_q    <= 1'b0;
        end else begin
            cap_sh <= {cap_sh[SYNC_STAGES-1:0], cap_in};
            eq_q   <= eq;
            trig   <= spev_clr;

            if (mode_chg)             ecnt <= '0;
            else if (rise && nth_mode) ecnt <= cap_evt ? '0 : ecnt + 1'b1;

            if (lo_we || hi_we) begin
                if (lo_we) ccr[7:0]   <= wdata;
                if (hi_we) ccr[W-1:8] <= wdata[HI_W-1:0];
            end else if (cap_evt) begin
                ccr <= cnt;
            end

            if (cmp_evt && state == CC_CMP_SET)      cmp_out <= 1'b1;
            else if (cmp_evt && state == CC_CMP_CLR) cmp_out <= 1'b0;

            if (cap_evt || cmp_evt) ev_flag <= 1'b1;
            else if (ev_clr)        ev_flag <= 1'b0;
        end
    end

    a_r12_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
    a_r13_ev_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || cmp_evt) |=> ev_flag);
    a_r9_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !lo_we && !hi_we) |=> (ccr == $past(cnt)));
    a_r11_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CC_CMP_SET && state != CC_CMP_CLR) |=> $stable(cmp_out));
    a_r10_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && state == CC_CMP_SET) |=> cmp_out);
    a_r8_edge_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (ecnt == '0));
endmodule

// File: rtl/tmr_cc.sv
module tmr_cc #(
    parameter int W           = 16,
    parameter int PS_W        = 2,
    parameter int ECNT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_tick,
    input  logic            ext_clk,
    input  logic            cap_in,
    input  logic            run_en,
    input  logic            clk_sel,
    input  logic            ext_nosync,
    input  logic [PS_W-1:0] presc,
    input  logic [3:0]      mode,
    input  logic [7:0]      wdata,
    input  logic            cnt_lo_we,
    input  logic            cnt_hi_we,
    input  logic            ccr_lo_we,
    input  logic            ccr_hi_we,
    input  logic            ovf_clr,
    input  logic            ev_clr,
    output logic [W-1:0]    cnt,
    output logic [W-1:0]    ccr,
    output logic            cmp_out,
    output logic            trig,
    output logic            ovf_flag,
    output logic            ev_flag
);
    logic inc, spev_clr;

    tmr_cc_clksel #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) u_clksel (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
        .clk_sel(clk_sel), .ext_nosync(ext_nosync), .run_en(run_en),
        .presc(presc), .cnt_wr(cnt_lo_we | cnt_hi_we), .inc(inc)
    );

    tmr_cc_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .inc(inc), .lo_we(cnt_lo_we), .hi_we(cnt_hi_we),
        .wdata(wdata), .spev_clr(spev_clr), .ovf_clr(ovf_clr),
        .cnt(cnt), .ovf_flag(ovf_flag)
    );

    tmr_cc_ccunit #(.W(W), .ECNT_W(ECNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ccunit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cap_in(cap_in), .cnt(cnt),
        .lo_we(ccr_lo_we), .hi_we(ccr_hi_we), .wdata(wdata), .ev_clr(ev_clr),
        .ccr(ccr), .cmp_out(cmp_out), .trig(trig), .ev_flag(ev_flag),
        .spev_clr(spev_clr)
    );
endmodule

// File: tb/tmr_cc_test.sv
`timescale 1ns/1ps
module tmr_cc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 0, ext_clk = 0, cap_in = 0, run_en = 0;
    logic        clk_sel = 0, ext_nosync = 0;
    logic [1:0]  presc = 0;
    logic [3:0]  mode = 0;
    logic [7:0]  wdata = 0;
    logic        cnt_lo_we = 0, cnt_hi_we = 0, ccr_lo_we = 0, ccr_hi_we = 0;
    logic        ovf_clr = 0, ev_clr = 0;
    logic [15:0] cnt, ccr;
    logic        cmp_out, trig, ovf_flag, ev_flag;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tmr_cc uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk), .cap_in(cap_in),
        .run_en(run_en), .clk_sel(clk_sel), .ext_nosync(ext_nosync), .presc(presc),
        .mode(mode), .wdata(wdata), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
        .ccr_lo_we(ccr_lo_we), .ccr_hi_we(ccr_hi_we), .ovf_clr(ovf_clr), .ev_clr(ev_clr),
        .cnt(cnt), .ccr(ccr), .cmp_out(cmp_out), .trig(trig),
        .ovf_flag(ovf_flag), .ev_flag(ev_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt, m_ccr, n_cnt, n_ccr;
    logic        m_ovf, m_ev, m_out, m_trig, m_eqq;
    logic [2:0]  m_es, m_cs;
    logic [3:0]  m_mode, nm;
    int          m_ec, m_pc, lim, n_ec, n_pc;
    logic        tk, cwr, do_inc, chg, rs, fl, capev, cmpev, spev, wrap;

    function automatic logic [3:0] norm_mode(input logic [3:0] c);
        if (c == 4'd0 || (c >= 4'd4 && c <= 4'd11)) return c;
        return 4'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ccr = 0; m_ovf = 0; m_ev = 0; m_out = 0; m_trig = 0;
            m_eqq = 0; m_es = 0; m_cs = 0; m_mode = 0; m_ec = 0; m_pc = 0;
        end else begin
            tk = clk_sel ? (ext_nosync ? (ext_clk & ~m_es[0]) : (m_es[1] & ~m_es[2])) : cyc_tick;
            lim = (1 << presc) - 1;
            cwr = cnt_lo_we | cnt_hi_we;
            do_inc = run_en && tk && (m_pc >= lim);
            if (!run_en || cwr) n_pc = 0;
            else if (tk)        n_pc = (m_pc >= lim) ? 0 : m_pc + 1;
            else                n_pc = m_pc;
            nm  = norm_mode(mode);
            chg = (nm != m_mode);
            rs  = m_cs[1] & ~m_cs[2];
            fl  = ~m_cs[1] & m_cs[2];
            capev = 0; cmpev = 0;
            if (!chg) begin
                if (m_mode == 4'd4) capev = fl;
                if (m_mode == 4'd5) capev = rs;
                if (m_mode == 4'd6) capev = rs && (m_ec == 3);
                if (m_mode == 4'd7) capev = rs && (m_ec == 15);
                if (m_mode >= 4'd8) cmpev = (m_cnt == m_ccr) && !m_eqq;
            end
            n_ec = m_ec;
            if (chg) n_ec = 0;
            else if (rs && (m_mode == 4'd6 || m_mode == 4'd7)) n_ec = capev ? 0 : m_ec + 1;
            spev = cmpev && (m_mode == 4'd11);
            n_cnt = m_cnt;
            if (cwr) begin
                if (cnt_lo_we) n_cnt[7:0]  = wdata;
                if (cnt_hi_we) n_cnt[15:8] = wdata;
            end else if (spev) n_cnt = 0;
            else if (do_inc)   n_cnt = m_cnt + 16'd1;
            wrap = !cwr && !spev && do_inc && (m_cnt == 16'hFFFF);
            n_ccr = m_ccr;
            if (ccr_lo_we || ccr_hi_we) begin
                if (ccr_lo_we) n_ccr[7:0]  = wdata;
                if (ccr_hi_we) n_ccr[15:8] = wdata;
            end else if (capev) n_ccr = m_cnt;
            if (cmpev && m_mode == 4'd8) m_out = 1;
            if (cmpev && m_mode == 4'd9) m_out = 0;
            m_ovf  = wrap ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
            m_ev   = (capev || cmpev) ? 1'b1 : (ev_clr ? 1'b0 : m_ev);
            m_trig = spev;
            m_eqq  = (m_cnt == m_ccr);
            m_cnt  = n_cnt; m_ccr = n_ccr; m_ec = n_ec; m_pc = n_pc; m_mode = nm;
            m_es   = {m_es[1:0], ext_clk};
            m_cs   = {m_cs[1:0], cap_in};
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 cnt vs model", cnt, m_cnt);
            chk("R6 ccr vs model", ccr, m_ccr);
            chk("R5 ovf vs model", ovf_flag, m_ovf);
            chk("R13 ev vs model", ev_flag, m_ev);
            chk("R10 out vs model", cmp_out, m_out);
            chk("R12 trig vs model", trig, m_trig);
        end
    end

    task automatic wr_cnt(input logic [15:0] v);
        wdata = v[7:0];  cnt_lo_we = 1; cyc(1); cnt_lo_we = 0;
        wdata = v[15:8]; cnt_hi_we = 1; cyc(1); cnt_hi_we = 0;
    endtask

    task automatic wr_ccr(input logic [15:0] v);
        wdata = v[7:0];  ccr_lo_we = 1; cyc(1); ccr_lo_we = 0;
        wdata = v[15:8]; ccr_hi_we = 1; cyc(1); ccr_hi_we = 0;
    endtask

    task automatic cap_pulse();
        cap_in = 1; cyc(3); cap_in = 0; cyc(3);
    endtask

    task automatic pulse_ev_clr();
        ev_clr = 1; cyc(1); ev_clr = 0;
    endtask

    initial begin
        #(20ns * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] saved;
        int trig_count, max_cnt;
        cyc(3);
        chk("R1 reset cnt", cnt, 0);
        chk("R1 reset ccr", ccr, 0);
        chk("R1 reset flags", {cmp_out, trig, ovf_flag, ev_flag}, 0);

        // R2: internal tick, 1:1
        rst_n = 1; run_en = 1; cyc_tick = 1; ext_nosync = 1;
        cyc(10);
        chk("R2 ten ticks", cnt, 10);
        chk("R3 nosync ignored on internal clock", cnt, 10);
        run_en = 0; cyc(5);
        chk("R2 hold when stopped", cnt, 10);

        // R4: prescale 1:4 then 1:8
        run_en = 1; presc = 2'b10;
        wdata = 8'h00; cnt_lo_we = 1; cnt_hi_we = 1; cyc(1); cnt_lo_we = 0; cnt_hi_we = 0;
        cyc(16);
        chk("R4 divide by 4", cnt, 4);
        presc = 2'b11; cyc(16);
        chk("R4 divide by 8", cnt, 6);
        presc = 2'b01; cyc(7);
        cyc_tick = 0; cyc(1); cyc_tick = 1; cyc(3);

        // R5: overflow
        presc = 2'b00;
        wdata = 8'hFE; cnt_lo_we = 1; cyc(1); cnt_lo_we = 0;
        wdata = 8'hFF; cnt_hi_we = 1; run_en = 0; cyc(1); cnt_hi_we = 0;
        run_en = 1; cyc(2);
        chk("R5 wrapped to zero", cnt, 0);
        chk("R5 overflow flag set", ovf_flag, 1);
        cyc(3);
        chk("R5 flag sticky", ovf_flag, 1);
        ovf_clr = 1; cyc(1); ovf_clr = 0; cyc(1);
        chk("R5 flag cleared", ovf_flag, 0);

        // R3: external clock latency
        run_en = 0; clk_sel = 1; ext_nosync = 1; ext_clk = 0; cyc(3);
        wr_cnt(16'h0000); run_en = 1; cyc(3);
        ext_clk = 1; cyc(1);
        chk("R3 unsync count after one edge", cnt, 1);
        cyc(2); ext_clk = 0; cyc(3);
        chk("R3 unsync single increment", cnt, 1);
        ext_nosync = 0; cyc(2);
        ext_clk = 1; cyc(2);
        chk("R3 sync not yet counted", cnt, 1);
        cyc(1);
        chk("R3 sync counted at third edge", cnt, 2);
        ext_clk = 0; cyc(3);
        for (int i = 0; i < 5; i++) begin
            ext_clk = 1; cyc(2); ext_clk = 0; cyc(2);
        end
        cyc(3);
        chk("R3 five external pulses", cnt, 7);
        clk_sel = 0; run_en = 0;

        // R6: capture rising / falling
        wr_cnt(16'h1234); mode = 4'b0101; cyc(2);
        cap_pulse();
        chk("R6 rising capture", ccr, 16'h1234);
        chk("R13 event on capture", ev_flag, 1);
        pulse_ev_clr(); cyc(1);
        chk("R13 event cleared", ev_flag, 0);
        mode = 4'b0100; cyc(2); wr_cnt(16'h0055);
        cap_pulse();
        chk("R6 falling capture", ccr, 16'h0055);

        // R7: every 4th and 16th rising edge
        mode = 4'b0110; cyc(2);
        for (int i = 0; i < 4; i++) begin
            wr_cnt(16'h0010 + 16'(i)); cap_pulse();
            if (i == 2) chk("R7 no capture before 4th edge", ccr, 16'h0055);
        end
        chk("R7 capture on 4th edge", ccr, 16'h0013);
        mode = 4'b0111; cyc(2);
        for (int i = 0; i < 16; i++) begin
            wr_cnt(16'h0100 + 16'(i)); cap_pulse();
            if (i == 14) chk("R7 no capture before 16th edge", ccr, 16'h0013);
        end
        chk("R7 capture on 16th edge", ccr, 16'h010F);

        // R8: mode change clears partial edge count
        mode = 4'b0110; cyc(2);
        cap_pulse(); cap_pulse();
        mode = 4'b0111; cyc(3); mode = 4'b0110; cyc(3);
        saved = ccr;
        wr_cnt(16'h0077);
        cap_pulse(); cap_pulse(); cap_pulse();
        chk("R8 partial count discarded", ccr, saved);
        wr_cnt(16'h0078); cap_pulse();
        chk("R8 capture after fresh 4 edges", ccr, 16'h0078);

        // R9: capture while counting
        mode = 4'b0101; cyc(2); run_en = 1; cyc_tick = 1; cyc(4);
        cap_pulse(); cap_pulse();
        chk("R9 pre-increment value captured", ccr, m_ccr);
        run_en = 0;

        // R10: compare set / clear
        mode = 4'b1000; wr_ccr(16'h0020); wr_cnt(16'h001E);
        run_en = 1; cyc(6);
        chk("R10 output set on match", cmp_out, 1);
        run_en = 0; mode = 4'b1001; wr_ccr(16'h0040); wr_cnt(16'h003C);
        run_en = 1; cyc(8);
        chk("R10 output cleared on match", cmp_out, 0);

        // R11: interrupt-only compare
        run_en = 0; mode = 4'b1000; wr_ccr(16'h0060); wr_cnt(16'h005E);
        run_en = 1; cyc(6);
        chk("R11 setup output high", cmp_out, 1);
        run_en = 0; pulse_ev_clr(); mode = 4'b1010;
        wr_ccr(16'h0080); wr_cnt(16'h007E);
        run_en = 1; cyc(6);
        chk("R11 event flag on match", ev_flag, 1);
        chk("R11 output unchanged", cmp_out, 1);

        // R12: special event trigger
        run_en = 0; cyc(1);
        wr_ccr(16'h0008);
        wdata = 8'h00; cnt_lo_we = 1; cnt_hi_we = 1; mode = 4'b1011; run_en = 1;
        cyc(1); cnt_lo_we = 0; cnt_hi_we = 0;
        trig_count = 0; max_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (trig) trig_count++;
            if (int'(cnt) > max_cnt) max_cnt = int'(cnt);
        end
        chk("R12 four trigger pulses", trig_count, 4);
        chk("R12 counter bounded by match value", max_cnt, 8);

        // R14: reserved codes behave as off
        run_en = 0; mode = 4'b1100; cyc(2); pulse_ev_clr();
        saved = {15'd0, cmp_out};
        wr_ccr(16'h0033); wr_cnt(16'h0032); wr_cnt(16'h0033); cyc(2);
        cap_pulse(); cap_pulse();
        chk("R14 no event in reserved code", ev_flag, 0);
        chk("R14 no capture in reserved code", ccr, 16'h0033);
        chk("R14 output untouched", cmp_out, saved[0]);
        mode = 4'b0010; cyc(2); wr_cnt(16'h0100);
        cap_pulse();
        chk("R14 code 0010 inert", {ev_flag, ccr}, {1'b0, 16'h0033});

        cyc(4);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule